// File: doc/BRIEF.md
# Chain-Terminated Sparse Row Dot-Product

This block multiplies a sparse matrix by a dense vector. The matrix arrives as a stream of nonzero records. Each record carries a signed value, the column that value sits in, and a continuation flag. The records are ordered row by row, and all nonzeros of a row are adjacent in the stream. The dense vector is first written into an internal register file through a simple write port. Once every element of that file has been written, the block accepts matrix records at a rate of one per cycle.

For each record, the block multiplies the value by the vector element that the column selects and adds the product to a running sum. A record whose continuation flag is 0 closes its row. On the edge that accepts that record, the sum, including the closing product, moves into an output register together with the row number, and the running sum is cleared. No further input is needed, so rows can follow each other with no idle cycles.

The output uses a valid/ready handshake. While a result is waiting, records that continue a row are still accepted, but a closing record is held back. A start pulse clears the row number and any partial sum, drops the pending result and re-opens the vector for loading.

Top module: `sparse_row_dot`

## Requirements
- R1: On the cycle after a reset cycle, `res_valid` and `ent_ready` are both 0.
- R2: `ent_ready` stays 0 until each of the N vector addresses has been written at least once since reset or start. It rises in the cycle that follows the edge taking the last missing write.
- R3: A row result equals the signed sum, over that row's records, of `ent_value` times the vector element at `ent_col`.
- R4: Accepting a record with `ent_chain` = 1 adds to the sum and produces no result. Accepting a record with `ent_chain` = 0 raises `res_valid` on the next cycle with the full row sum, and the next row starts again from zero.
- R5: `res_row` is 0 for the first result after reset or start and rises by one with each later result.
- R6: With `res_ready` held at 1, a record is accepted on every cycle, including a run of one-record rows, and each closing record yields its result on the following cycle.
- R7: While `res_valid` = 1 and `res_ready` = 0, `ent_ready` is 0 for a closing record and 1 for a continuing record.
- R8: While a result is stalled, `res_valid`, `res_sum` and `res_row` hold their values.
- R9: Vector writes made while records are being accepted leave the vector unchanged.
- R10: A start pulse drops `res_valid`, clears the partial sum and the row number, and returns the block to the loading phase, with `ent_ready` at 0.
- R11: A row of N records, each a full-scale product, gives the exact sum without overflow. The accumulator width is 2*DATA_W + log2(N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Clears row number and partial sum, re-enters the loading phase |
| vec_we | input | 1 | Vector element write enable |
| vec_waddr | input | IDX_W | Vector element address |
| vec_wdata | input | DATA_W | Vector element value, signed |
| ent_valid | input | 1 | A matrix record is offered |
| ent_ready | output | 1 | The block takes the offered record on this edge |
| ent_value | input | DATA_W | Nonzero value, signed |
| ent_col | input | IDX_W | Column of the value, below N |
| ent_chain | input | 1 | 1: more records of this row follow; 0: last record of the row |
| res_valid | output | 1 | A row result is presented |
| res_ready | input | 1 | The consumer takes the result on this edge |
| res_sum | output | ACC_W | Row dot-product, signed |
| res_row | output | ROW_W | Row number of the result |

## Verification
A wrong accumulator shows at the ports as a wrong `res_sum` on the first closing record after the fault. A sum that was not cleared carries over into the next row's result one row later. A faulty row counter shows in `res_row` on the next result. A wrong load mask or wrong gating shows as `ent_ready` being high during loading, or low while streaming, in the very cycle of the fault. A stall fault shows as a result that changes or disappears while `res_ready` is low.

// File: rtl/sparse_row_dot_pkg.sv
// Shared helpers for the sparse row dot-product block.
package sparse_row_dot_pkg;

    // Accumulator width that holds n full-scale products of dw-bit signed operands.
    function automatic int acc_width(input int dw, input int n);
        return 2 * dw + $clog2(n);
    endfunction

endpackage

// File: rtl/sparse_vec_regfile.sv
// Dense vector store. Holds N signed elements plus a per-element written
// mask. Writes are taken only while the mask is incomplete; once all N are
// written the store is locked until clear. Assumes rd_addr < N.
module sparse_vec_regfile #(
    parameter int DATA_W = 16,
    parameter int N      = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_addr,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_addr,
    output logic signed [DATA_W-1:0] rd_data,
    output logic                     full
);

    logic signed [DATA_W-1:0] mem [N];
    logic                     mask [N];

    for (genvar g = 0; g < N; g++) begin : g_elem
        // Store one element and its written flag; locked once all are written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g]  <= '0;
                mask[g] <= 1'b0;
            end else if (clear) begin
                mask[g] <= 1'b0;
            end else if (wr_en && !full && wr_addr == IDX_W'(g)) begin
                mem[g]  <= wr_data;
                mask[g] <= 1'b1;
            end
        end
    end

    // Vector is complete when every element has been written.
    always_comb begin
        full = 1'b1;
        for (int i = 0; i < N; i++) full = full & mask[i];
    end

    // Asynchronous read of the selected element.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sparse_mac_accum.sv
// Signed multiply-accumulate for one row. sum_out is the running sum plus
// the current product; the stored sum clears after a closing record.
module sparse_mac_accum #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 36,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic                     last,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [ACC_W-1:0]  sum_out
);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_q;

    // Product sign-extended into the accumulator width and added.
    always_comb begin
        prod    = a * b;
        sum_out = acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    // Running sum: cleared on start or row end, else advanced on each record.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  acc_q <= '0;
        else if (step && last) acc_q <= '0;
        else if (step)        acc_q <= sum_out;
    end

endmodule

// File: rtl/sparse_result_stage.sv
// Output register with valid/ready and the row counter. A new result may
// be loaded only when can_load is high; the caller guarantees this.
module sparse_result_stage #(
    parameter int ACC_W = 36,
    parameter int ROW_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] sum_in,
    input  logic                    out_ready,
    output logic                    can_load,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_sum,
    output logic [ROW_W-1:0]        out_row
);

    logic [ROW_W-1:0] row_q;

    // Slot is free when empty or being drained this cycle.
    assign can_load = !out_valid || out_ready;

    // Result register: capture on load, drop when consumed or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_row   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_sum   <= sum_in;
            out_row   <= row_q;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Row counter: next row number to report.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) row_q <= '0;
        else if (load)       row_q <= row_q + 1'b1;
    end

endmodule

// File: rtl/sparse_row_dot.sv
// Sparse matrix times dense vector. Vector is loaded first; matrix records
// {value, column, chain} then stream in row order, one per cycle. A record
// with chain = 0 closes its row and its result is registered on the same
// edge. Assumes columns are below N and rows are contiguous in the stream.
module sparse_row_dot
    import sparse_row_dot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int N      = 16,
    parameter int ROW_W  = 8,
    localparam int IDX_W = $clog2(N),
    localparam int ACC_W = acc_width(DATA_W, N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     vec_we,
    input  logic [IDX_W-1:0]         vec_waddr,
    input  logic signed [DATA_W-1:0] vec_wdata,
    input  logic                     ent_valid,
    output logic                     ent_ready,
    input  logic signed [DATA_W-1:0] ent_value,
    input  logic [IDX_W-1:0]         ent_col,
    input  logic                     ent_chain,
    output logic                     res_valid,
    input  logic                     res_ready,
    output logic signed [ACC_W-1:0]  res_sum,
    output logic [ROW_W-1:0]         res_row
);

    logic                     vec_full;
    logic signed [DATA_W-1:0] x_elem;
    logic signed [ACC_W-1:0]  row_sum;
    logic                     slot_free;
    logic                     accept;
    logic                     emit;

    // Handshake: streaming only with a full vector; closing records need a free slot.
    always_comb begin
        ent_ready = vec_full && !start && (ent_chain || slot_free);
        accept    = ent_valid && ent_ready;
        emit      = accept && !ent_chain;
    end

    sparse_vec_regfile #(.DATA_W(DATA_W), .N(N)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .wr_en   (vec_we),
        .wr_addr (vec_waddr),
        .wr_data (vec_wdata),
        .rd_addr (ent_col),
        .rd_data (x_elem),
        .full    (vec_full)
    );

    sparse_mac_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .step    (accept),
        .last    (!ent_chain),
        .a       (ent_value),
        .b       (x_elem),
        .sum_out (row_sum)
    );

    sparse_result_stage #(.ACC_W(ACC_W), .ROW_W(ROW_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .load      (emit),
        .sum_in    (row_sum),
        .out_ready (res_ready),
        .can_load  (slot_free),
        .out_valid (res_valid),
        .out_sum   (res_sum),
        .out_row   (res_row)
    );

endmodule

// File: rtl/sparse_row_dot_chk.sv
// Property checker for sparse_row_dot, attached by bind.
module sparse_row_dot_chk #(
    parameter int ACC_W = 36,
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ent_valid,
    input logic             ent_ready,
    input logic             ent_chain,
    input logic             res_valid,
    input logic             res_ready,
    input logic [ACC_W-1:0] res_sum,
    input logic [ROW_W-1:0] res_row,
    input logic             vec_full
);

    logic after_rst_q = 1'b0;

    // Remember that the previous edge saw reset asserted.
    always_ff @(posedge clk) after_rst_q <= !rst_n;

    // R1: outputs idle after a reset cycle.
    always @(posedge clk) begin
        if (after_rst_q) begin
            a_r1_reset_idle: assert (!res_valid && !ent_ready);
        end
    end

    // R2: records are taken only with a complete vector.
    a_r2_ready_needs_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ent_ready |-> vec_full);

    // R4: a closing record yields a result on the next cycle.
    a_r4_last_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && ent_ready && !ent_chain && !start) |=> res_valid);

    // R5: consecutive results carry consecutive row numbers.
    a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && ent_ready && !ent_chain && res_valid && res_ready && !start)
        |=> res_row == ROW_W'($past(res_row) + 1'b1));

    // R7: a stalled result blocks closing records.
    a_r7_stall_blocks_last: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready && !ent_chain) |-> !ent_ready);

    // R8: a stalled result holds its contents.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready && !start)
        |=> (res_valid && $stable(res_sum) && $stable(res_row)));

endmodule

bind sparse_row_dot sparse_row_dot_chk #(.ACC_W(ACC_W), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ent_valid (ent_valid),
    .ent_ready (ent_ready),
    .ent_chain (ent_chain),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_sum   (res_sum),
    .res_row   (res_row),
    .vec_full  (vec_full)
);

// File: tb/test_sparse_row_dot.sv
module test_sparse_row_dot;

    localparam int DATA_W = 16;
    localparam int N      = 16;
    localparam int ROW_W  = 8;
    localparam int IDX_W  = $clog2(N);
    localparam int ACC_W  = 2 * DATA_W + IDX_W;
    localparam int NTAB   = 12;

    // Record table: {value, column, chain}
    localparam logic [DATA_W+IDX_W:0] TAB [NTAB] = '{
        {16'sd5,      4'd3,  1'b1},
        {-16'sd2,     4'd0,  1'b1},
        {16'sd10,     4'd15, 1'b0},
        {16'sd100,    4'd7,  1'b0},
        {-16'sd300,   4'd1,  1'b0},
        {16'sd1,      4'd2,  1'b1},
        {16'sd1,      4'd2,  1'b1},
        {16'sd1,      4'd2,  1'b1},
        {16'sd1,      4'd2,  1'b0},
        {16'sd32767,  4'd15, 1'b1},
        {-16'sd32768, 4'd0,  1'b0},
        {16'sd0,      4'd4,  1'b0}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic                     vec_we = 1'b0;
    logic [IDX_W-1:0]         vec_waddr = '0;
    logic signed [DATA_W-1:0] vec_wdata = '0;
    logic                     ent_valid = 1'b0;
    logic                     ent_ready;
    logic signed [DATA_W-1:0] ent_value = '0;
    logic [IDX_W-1:0]         ent_col = '0;
    logic                     ent_chain = 1'b1;
    logic                     res_valid;
    logic                     res_ready = 1'b1;
    logic signed [ACC_W-1:0]  res_sum;
    logic [ROW_W-1:0]         res_row;

    int     n_chk = 0;
    int     n_err = 0;
    bit     done = 1'b0;
    longint xm [N];
    int     waits;

    sparse_row_dot #(.DATA_W(DATA_W), .N(N), .ROW_W(ROW_W)) i_sparse_row_dot (.*);

    always #2 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    // Write the whole vector with base + step*i; checks ready gating (R2).
    task automatic load_vec(input longint base, input longint stp);
        ent_valid = 1'b1; ent_chain = 1'b1;
        for (int i = 0; i < N; i++) begin
            vec_we = 1'b1; vec_waddr = IDX_W'(i);
            vec_wdata = DATA_W'(base + stp * i);
            xm[i] = longint'(vec_wdata);
            #1 check("R2 ready low while loading", longint'(ent_ready), 0);
            @(posedge clk); @(negedge clk);
        end
        vec_we = 1'b0; ent_valid = 1'b0;
        #1;
        ent_valid = 1'b1;
        #1 check("R2 ready after last write", longint'(ent_ready), 1);
        ent_valid = 1'b0;
        @(negedge clk);
    endtask

    // Offer one record at a negedge, wait for acceptance, return at next negedge.
    task automatic send(input logic signed [DATA_W-1:0] v, input logic [IDX_W-1:0] c,
                        input logic ch);
        ent_valid = 1'b1; ent_value = v; ent_col = c; ent_chain = ch;
        waits = 0;
        #1;
        while (!ent_ready) begin
            @(negedge clk); waits++; #1;
        end
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle();
        ent_valid = 1'b0; ent_chain = 1'b1;
    endtask

    initial begin
        #(4 * 20000);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        longint sum;
        longint row_exp;
        longint held;

        // R1: reset state
        ent_valid = 1'b1; ent_chain = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 res_valid in reset", longint'(res_valid), 0);
        check("R1 ent_ready in reset", longint'(ent_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 res_valid after reset", longint'(res_valid), 0);
        check("R1 ent_ready after reset", longint'(ent_ready), 0);
        ent_valid = 1'b0;

        load_vec(-50, 7);

        // Table walk: R3, R4, R5, R6
        sum = 0; row_exp = 0;
        for (int k = 0; k < NTAB; k++) begin
            logic signed [DATA_W-1:0] v;
            logic [IDX_W-1:0] c;
            logic ch;
            {v, c, ch} = TAB[k];
            send(v, c, ch);
            check("R6 no wait with ready high", longint'(waits), 0);
            sum += longint'(v) * xm[c];
            if (!ch) begin
                check("R4 result valid after last", longint'(res_valid), 1);
                check("R3 row sum", longint'(res_sum), sum);
                check("R5 row number", longint'(res_row), row_exp);
                row_exp++; sum = 0;
            end else begin
                check("R4 no result on chained", longint'(res_valid), 0);
            end
        end
        idle();
        @(negedge clk);

        // R7, R8: stall
        res_ready = 1'b0;
        send(16'sd3, 4'd1, 1'b0);
        held = 3 * xm[1];
        check("R3 stall row sum", longint'(res_sum), held);
        check("R5 stall row number", longint'(res_row), row_exp);
        row_exp++;
        send(16'sd2, 4'd5, 1'b1);
        check("R7 chained taken while stalled", longint'(waits), 0);
        ent_valid = 1'b1; ent_value = 16'sd4; ent_col = 4'd6; ent_chain = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1 check("R7 closing blocked while stalled", longint'(ent_ready), 0);
            check("R8 valid held", longint'(res_valid), 1);
            check("R8 sum held", longint'(res_sum), held);
            @(negedge clk);
        end
        res_ready = 1'b1;
        #1 check("R7 closing taken once drained", longint'(ent_ready), 1);
        @(posedge clk); @(negedge clk);
        check("R3 row after stall", longint'(res_sum), 2 * xm[5] + 4 * xm[6]);
        check("R5 row after stall", longint'(res_row), row_exp);
        idle();
        @(negedge clk);

        // R9: write during streaming ignored
        vec_we = 1'b1; vec_waddr = 4'd2; vec_wdata = 16'sd999;
        @(negedge clk);
        vec_we = 1'b0;
        send(16'sd1, 4'd2, 1'b0);
        check("R9 vector unchanged", longint'(res_sum), xm[2]);
        idle();
        @(negedge clk);

        // R10: start clears partial sum and row number
        send(16'sd9, 4'd3, 1'b1);
        idle();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ent_valid = 1'b1;
        #1 check("R10 ready low after start", longint'(ent_ready), 0);
        check("R10 valid low after start", longint'(res_valid), 0);
        ent_valid = 1'b0;
        load_vec(-32768, 0);

        // R11: full-scale rows
        for (int i = 0; i < N; i++) send(-16'sd32768, IDX_W'(i), i < N - 1);
        check("R11 positive full scale", longint'(res_sum), longint'(1) << 34);
        check("R10 row restarts at zero", longint'(res_row), 0);
        for (int i = 0; i < N; i++) send(16'sd32767, IDX_W'(i), i < N - 1);
        check("R11 negative full scale", longint'(res_sum), -longint'(N) * 32767 * 32768);
        check("R5 second row after start", longint'(res_row), 1);
        idle();
        @(negedge clk);
        check("R4 valid drops after drain", longint'(res_valid), 0);

        finish_run();
    end

endmodule